// File: doc/BRIEF.md
# GPIO Interrupt Routing Controller

This block is a register-mapped general-purpose I/O port of up to 32 lines that can also raise interrupts. Software sets each line's output value and drive enable through registers and reads back the synchronized pin levels. Each line has a mask bit, a polarity bit and an edge-select bit. Together these bits arm the line to fire on a low level, a high level, a falling edge or a rising edge.

Every line carries its own routing byte, which steers the line to one of several interrupt wires or to none. Each interrupt wire is the registered OR of all the armed lines steered to it, so lines can share a wire. A per-line bypass bit shortens the input path from two sampling flops to one, for lines that are already synchronous to the clock.

The register port accepts one request per cycle and never stalls. A read answers on `rsp_valid` one cycle after the request, and there is no back-pressure on the response, so the requester must be able to take it. Addresses are word indices, and the byte offset is four times the index.

Top module: `gpio_irq_router`

## Requirements
- R1: After reset, the mask, polarity, edge-select, bypass, direction and output registers read 0. Every routing byte reads 0x80, `gpio_oe` and `irq_o` are all low, and `rsp_valid` is low.
- R2: A write with `req_valid` and `req_write` updates the addressed register at the next clock edge. A read with `req_valid` and `req_write` low returns its data with `rsp_valid` high exactly one cycle later. Register bits above the line count, unused addresses and writes to the input register have no effect and read 0. The registers are: index 0 input (read-only), 1 output value, 2 direction, 3 mask, 4 polarity, 5 edge select, 6 bypass, 8 to 15 routing.
- R3: The input register (index 0) shows each pin after two clock edges, or after one edge when the line's bypass bit is 1.
- R4: `gpio_out` equals the output-value register and `gpio_oe` equals the direction register, where a bit of 1 means driven.
- R5: A line whose mask bit is 0 never affects `irq_o`.
- R6: With polarity 0 and edge-select 0, an armed line fires for as long as its sampled input is low.
- R7: With polarity 1 and edge-select 0, an armed line fires for as long as its sampled input is high.
- R8: With polarity 0 and edge-select 1, an armed line fires on a high-to-low change of its sampled input. It produces exactly one cycle of assertion on its wire, and the opposite change does not fire.
- R9: With polarity 1 and edge-select 1, an armed line fires as a one-cycle pulse on a low-to-high change only.
- R10: Routing register 8+w holds the bytes of lines 4w to 4w+3, with line 4w+b in bits [8b+7:8b]. A line drives wire k only when its byte has bit 7 = 0 and bits [6:0] = k. Bit 7 = 1, or an index at or above the wire count, routes the line nowhere.
- R11: Each wire is the OR of all armed lines routed to it. It stays high while any one of them fires.
- R12: `irq_o` is registered. It rises on the third clock edge after a pin change, or on the second edge with bypass. A level-mode wire falls on the same edge count after the pin returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Register request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 4 | Word index of the register |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read |
| rsp_rdata | output | 32 | Read data |
| gpio_in | input | NLINES | Pin levels, asynchronous |
| gpio_out | output | NLINES | Output values for the pins |
| gpio_oe | output | NLINES | Drive enables for the pins |
| irq_o | output | NIRQ | Interrupt wires |

## Verification
The bench changes pins half a cycle before a rising edge. It then samples `irq_o` at the falling edge after each of the next four rising edges. A wire must stay low after the first and second edges and rise after the third, or after the second with bypass. An edge-mode wire must be low again after the fourth edge, while a level-mode wire is still high. Reads are sampled at the falling edge that follows the capturing edge. The two-edge synchronizer is checked by reading the input register one edge after a pin change, when the read must still show the old value unless bypass is set.

// File: rtl/gir_pkg.sv
package gir_pkg;
  localparam int MAX_LINES = 32;
  localparam int ADDR_W    = 4;
  localparam int DATA_W    = 32;

  localparam logic [ADDR_W-1:0] ADR_DIN  = 4'd0;
  localparam logic [ADDR_W-1:0] ADR_DOUT = 4'd1;
  localparam logic [ADDR_W-1:0] ADR_DIR  = 4'd2;
  localparam logic [ADDR_W-1:0] ADR_MASK = 4'd3;
  localparam logic [ADDR_W-1:0] ADR_POL  = 4'd4;
  localparam logic [ADDR_W-1:0] ADR_EDGE = 4'd5;
  localparam logic [ADDR_W-1:0] ADR_BYP  = 4'd6;

  localparam logic [7:0] ROUTE_NONE = 8'h80;

  typedef logic [7:0] route_t;
endpackage

// File: rtl/gir_sync.sv
module gir_sync #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin_i,
  input  logic [N-1:0] byp_i,
  output logic [N-1:0] smp_o,
  output logic [N-1:0] prev_o
);
  for (genvar i = 0; i < N; i++) begin : g_line
    logic st1_q, st2_q, prev_q;
    logic smp;

    assign smp = byp_i[i] ? st1_q : st2_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        st1_q  <= 1'b0;
        st2_q  <= 1'b0;
        prev_q <= 1'b0;
      end else begin
        st1_q  <= pin_i[i];
        st2_q  <= st1_q;
        prev_q <= smp;
      end
    end

    assign smp_o[i]  = smp;
    assign prev_o[i] = prev_q;
  end
endmodule

// File: rtl/gir_detect.sv
module gir_detect #(
  parameter int N = 32
) (
  input  logic [N-1:0] smp_i,
  input  logic [N-1:0] prev_i,
  input  logic [N-1:0] mask_i,
  input  logic [N-1:0] pol_i,
  input  logic [N-1:0] esel_i,
  output logic [N-1:0] trig_o
);
  for (genvar i = 0; i < N; i++) begin : g_line
    logic lvl_hit, edg_hit;
    assign lvl_hit = pol_i[i] ? smp_i[i] : ~smp_i[i];
    assign edg_hit = pol_i[i] ? (smp_i[i] & ~prev_i[i]) : (~smp_i[i] & prev_i[i]);
    assign trig_o[i] = mask_i[i] & (esel_i[i] ? edg_hit : lvl_hit);
  end
endmodule

// File: rtl/gir_route.sv
module gir_route
  import gir_pkg::*;
#(
  parameter int N    = 32,
  parameter int NOUT = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N-1:0]         trig_i,
  input  route_t [N-1:0]       map_i,
  output logic [NOUT-1:0]      irq_o
);
  logic [NOUT-1:0] acc;
  logic [NOUT-1:0] irq_q;

  always_comb begin
    acc = '0;
    for (int i = 0; i < N; i++) begin
      for (int k = 0; k < NOUT; k++) begin
        if (!map_i[i][7] && (map_i[i][6:0] == 7'(k)))
          acc[k] = acc[k] | trig_i[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= '0;
    else        irq_q <= acc;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/gir_regs.sv
module gir_regs
  import gir_pkg::*;
#(
  parameter int N = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic [N-1:0]      din_i,
  output logic [N-1:0]      dout_o,
  output logic [N-1:0]      dir_o,
  output logic [N-1:0]      mask_o,
  output logic [N-1:0]      pol_o,
  output logic [N-1:0]      esel_o,
  output logic [N-1:0]      byp_o,
  output route_t [N-1:0]    map_o
);
  logic [N-1:0]   dout_q, dir_q, mask_q, pol_q, esel_q, byp_q;
  route_t [N-1:0] map_q;
  logic [DATA_W-1:0] rmux;
  logic [DATA_W-1:0] rdata_q;
  logic              rvalid_q;
  logic              wr_en, rd_en;

  assign wr_en = req_valid & req_write;
  assign rd_en = req_valid & ~req_write;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dout_q <= '0;
      dir_q  <= '0;
      mask_q <= '0;
      pol_q  <= '0;
      esel_q <= '0;
      byp_q  <= '0;
      for (int i = 0; i < N; i++) map_q[i] <= ROUTE_NONE;
    end else if (wr_en) begin
      case (req_addr)
        ADR_DOUT: dout_q <= req_wdata[N-1:0];
        ADR_DIR:  dir_q  <= req_wdata[N-1:0];
        ADR_MASK: mask_q <= req_wdata[N-1:0];
        ADR_POL:  pol_q  <= req_wdata[N-1:0];
        ADR_EDGE: esel_q <= req_wdata[N-1:0];
        ADR_BYP:  byp_q  <= req_wdata[N-1:0];
        default: ;
      endcase
      for (int i = 0; i < N; i++) begin
        if (req_addr[3] && (req_addr[2:0] == 3'(i / 4)))
          map_q[i] <= req_wdata[(i % 4) * 8 +: 8];
      end
    end
  end

  always_comb begin
    rmux = '0;
    case (req_addr)
      ADR_DIN:  rmux = DATA_W'(din_i);
      ADR_DOUT: rmux = DATA_W'(dout_q);
      ADR_DIR:  rmux = DATA_W'(dir_q);
      ADR_MASK: rmux = DATA_W'(mask_q);
      ADR_POL:  rmux = DATA_W'(pol_q);
      ADR_EDGE: rmux = DATA_W'(esel_q);
      ADR_BYP:  rmux = DATA_W'(byp_q);
      default: begin
        for (int i = 0; i < N; i++) begin
          if (req_addr[3] && (req_addr[2:0] == 3'(i / 4)))
            rmux[(i % 4) * 8 +: 8] = map_q[i];
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      rvalid_q <= rd_en;
      if (rd_en) rdata_q <= rmux;
    end
  end

  assign rsp_valid = rvalid_q;
  assign rsp_rdata = rdata_q;
  assign dout_o    = dout_q;
  assign dir_o     = dir_q;
  assign mask_o    = mask_q;
  assign pol_o     = pol_q;
  assign esel_o    = esel_q;
  assign byp_o     = byp_q;
  assign map_o     = map_q;
endmodule

// File: rtl/gpio_irq_router.sv
module gpio_irq_router
  import gir_pkg::*;
#(
  parameter int NLINES = 32,
  parameter int NIRQ   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [3:0]        req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  input  logic [NLINES-1:0] gpio_in,
  output logic [NLINES-1:0] gpio_out,
  output logic [NLINES-1:0] gpio_oe,
  output logic [NIRQ-1:0]   irq_o
);
  logic [NLINES-1:0]   smp_w, prev_w, trig_w;
  logic [NLINES-1:0]   mask_w, pol_w, esel_w, byp_w;
  route_t [NLINES-1:0] map_w;

  gir_regs #(.N(NLINES)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .din_i     (smp_w),
    .dout_o    (gpio_out),
    .dir_o     (gpio_oe),
    .mask_o    (mask_w),
    .pol_o     (pol_w),
    .esel_o    (esel_w),
    .byp_o     (byp_w),
    .map_o     (map_w)
  );

  gir_sync #(.N(NLINES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_i  (gpio_in),
    .byp_i  (byp_w),
    .smp_o  (smp_w),
    .prev_o (prev_w)
  );

  gir_detect #(.N(NLINES)) u_detect (
    .smp_i  (smp_w),
    .prev_i (prev_w),
    .mask_i (mask_w),
    .pol_i  (pol_w),
    .esel_i (esel_w),
    .trig_o (trig_w)
  );

  gir_route #(.N(NLINES), .NOUT(NIRQ)) u_route (
    .clk    (clk),
    .rst_n  (rst_n),
    .trig_i (trig_w),
    .map_i  (map_w),
    .irq_o  (irq_o)
  );
endmodule

// File: rtl/gir_checker.sv
module gir_checker
  import gir_pkg::*;
#(
  parameter int N    = 32,
  parameter int NOUT = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_write,
  input logic            rsp_valid,
  input logic [NOUT-1:0] irq_o,
  input logic [N-1:0]    trig,
  input logic [N-1:0]    mask_q,
  input logic [N-1:0]    esel_q,
  input route_t [N-1:0]  map_q
);
  logic any_routed;
  always_comb begin
    any_routed = 1'b0;
    for (int i = 0; i < N; i++) any_routed = any_routed | ~map_q[i][7];
  end

  // R2: a read answers exactly one cycle later
  p_read_answer_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid);

  // R2: no response without a read
  p_no_spurious_rsp_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write) |=> !rsp_valid);

  // R5: with every mask bit clear the wires are quiet next cycle
  p_masked_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |=> (irq_o == '0));

  // R8 / R9: an edge-mode trigger never lasts two cycles
  p_edge_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((trig & esel_q & $past(trig & esel_q)) == '0));

  // R10: nothing routed means no wire rises
  p_unrouted_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !any_routed |=> (irq_o == '0));
endmodule

bind gpio_irq_router gir_checker #(.N(NLINES), .NOUT(NIRQ)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_write (req_write),
  .rsp_valid (rsp_valid),
  .irq_o     (irq_o),
  .trig      (trig_w),
  .mask_q    (mask_w),
  .esel_q    (esel_w),
  .map_q     (map_w)
);

// File: tb/gpio_irq_router_tb.sv
module gpio_irq_router_tb;
  localparam int NL = 8;
  localparam int NO = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_write = 1'b0;
  logic [3:0]    req_addr = '0;
  logic [31:0]   req_wdata = '0;
  logic          rsp_valid;
  logic [31:0]   rsp_rdata;
  logic [NL-1:0] gpio_in = '1;
  logic [NL-1:0] gpio_out, gpio_oe;
  logic [NO-1:0] irq_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  gpio_irq_router #(.NLINES(NL), .NIRQ(NO)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .gpio_in(gpio_in), .gpio_out(gpio_out),
    .gpio_oe(gpio_oe), .irq_o(irq_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    check("R2 rsp_valid", 32'(rsp_valid), 32'd1);
    d = rsp_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [NO-1:0] want;
    logic [NL-1:0] idle_v;
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 irq", 32'(irq_o), 0);
    check("R1 oe", 32'(gpio_oe), 0);
    check("R1 rsp_valid", 32'(rsp_valid), 0);
    rd(4'd3, d); check("R1 mask", d, 0);
    rd(4'd4, d); check("R1 pol", d, 0);
    rd(4'd5, d); check("R1 edge", d, 0);
    rd(4'd6, d); check("R1 bypass", d, 0);
    rd(4'd1, d); check("R1 dout", d, 0);
    rd(4'd8, d); check("R1 map0", d, 32'h80808080);
    rd(4'd9, d); check("R1 map1", d, 32'h80808080);

    // R2 readback, upper bits, unused addresses, read-only input
    wr(4'd4, 32'hFFFF_FFFF); rd(4'd4, d); check("R2 pol width", d, 32'h0000_00FF);
    wr(4'd4, 32'h0);
    wr(4'd10, 32'h1234_5678); rd(4'd10, d); check("R2 map beyond lines", d, 0);
    wr(4'd7, 32'hFFFF_FFFF); rd(4'd7, d); check("R2 unused addr", d, 0);
    wr(4'd0, 32'h0000_0000); rd(4'd0, d); check("R2 input read-only", d, 32'h0000_00FF);
    wr(4'd9, 32'hA1B2_C3D4); rd(4'd9, d); check("R2 map readback", d, 32'hA1B2_C3D4);

    // R4 pin outputs
    wr(4'd1, 32'hA5); wr(4'd2, 32'h3C);
    check("R4 gpio_out", 32'(gpio_out), 32'hA5);
    check("R4 gpio_oe", 32'(gpio_oe), 32'h3C);

    // R3 synchronizer depth, plain then bypass
    gpio_in = 8'h0F; @(negedge clk);
    rd(4'd0, d); check("R3 two-stage old value", d, 32'hFF);
    rd(4'd0, d); check("R3 two-stage new value", d, 32'h0F);
    wr(4'd6, 32'h01);
    gpio_in = 8'h0E; @(negedge clk);
    rd(4'd0, d); check("R3 bypass line early", d, 32'h0E | 32'h0);
    wr(4'd6, 32'h0);
    gpio_in = 8'hFF; idle(4);

    // R5..R9, R12 sweep: line i -> wire i%NO
    wr(4'd8, 32'h0302_0100); wr(4'd9, 32'h0302_0100);
    for (int i = 0; i < NL; i++) begin
      for (int m = 0; m < 4; m++) begin
        logic pol, edg;
        pol = m[0]; edg = m[1];
        want = NO'(1 << (i % NO));
        idle_v = pol ? '0 : '1;
        gpio_in = idle_v; idle(4);
        wr(4'd4, pol ? 32'(1 << i) : 32'h0);
        wr(4'd5, edg ? 32'(1 << i) : 32'h0);
        wr(4'd3, 32'(1 << i));
        idle(3);
        check("R5 armed idle quiet", 32'(irq_o), 0);
        gpio_in = idle_v ^ NL'(1 << i);
        idle(1); check("R12 edge1", 32'(irq_o), 0);
        idle(1); check("R12 edge2", 32'(irq_o), 0);
        idle(1); check(pol ? "R7/R9 fire" : "R6/R8 fire", 32'(irq_o), 32'(want));
        idle(1);
        if (edg) check(pol ? "R9 pulse ends" : "R8 pulse ends", 32'(irq_o), 0);
        else     check(pol ? "R7 level held" : "R6 level held", 32'(irq_o), 32'(want));
        gpio_in = idle_v;
        if (edg) begin
          for (int k = 0; k < 4; k++) begin
            idle(1); check(pol ? "R9 falling ignored" : "R8 rising ignored", 32'(irq_o), 0);
          end
        end else begin
          idle(2); check("R12 level still up", 32'(irq_o), 32'(want));
          idle(1); check(pol ? "R7 level drop" : "R6 level drop", 32'(irq_o), 0);
        end
        wr(4'd3, 32'h0);
        // R5 masked line toggled
        gpio_in = idle_v ^ NL'(1 << i);
        idle(5); check("R5 masked no effect", 32'(irq_o), 0);
        gpio_in = idle_v;
      end
    end

    // R12 bypass latency, level high on line 0
    gpio_in = 8'h00; idle(4);
    wr(4'd4, 32'h01); wr(4'd5, 32'h0); wr(4'd6, 32'h01); wr(4'd3, 32'h01);
    gpio_in = 8'h01;
    idle(1); check("R12 bypass edge1", 32'(irq_o), 0);
    idle(1); check("R12 bypass edge2", 32'(irq_o), 32'h1);
    gpio_in = 8'h00; wr(4'd6, 32'h0); idle(4);

    // R10 routing field decode, line 0 level high
    gpio_in = 8'h01; idle(3);
    wr(4'd8, 32'h0302_0180); idle(3);
    check("R10 unrouted bit7", 32'(irq_o), 0);
    wr(4'd8, 32'h0302_0105); idle(3);
    check("R10 index beyond wires", 32'(irq_o), 0);
    wr(4'd8, 32'h0302_0103); idle(3);
    check("R10 routed to wire 3", 32'(irq_o), 32'h8);
    wr(4'd8, 32'h0302_01A3); idle(3);
    check("R10 bit7 overrides index", 32'(irq_o), 0);

    // R11 two lines share wire 2
    gpio_in = 8'h00; wr(4'd8, 32'h8080_0202);
    wr(4'd4, 32'h03); wr(4'd3, 32'h03); idle(4);
    check("R11 idle", 32'(irq_o), 0);
    gpio_in = 8'h03; idle(4);
    check("R11 both", 32'(irq_o), 32'h4);
    gpio_in = 8'h02; idle(4);
    check("R11 one left", 32'(irq_o), 32'h4);
    gpio_in = 8'h00; idle(4);
    check("R11 none", 32'(irq_o), 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule